// File: doc/BRIEF.md
# Sticky Right Shifter, 128-bit

This block shifts a 128-bit value right by a variable count. The value arrives as two 64-bit halves, an upper and a lower one. Every set bit that falls off the bottom is folded into bit 0 of the result by an OR. That bit then serves as the sticky indication for a rounding stage further down the datapath. The count is eight bits wide. Every count from 128 to 255 collapses the value to a single "anything was there" bit.

All counts follow one rule: the halves shift together as one 128-bit word, and the OR of every discarded bit is merged into result bit 0. The exact-half count, the counts between one and two halves, and the saturated counts are special cases of that rule, each with its own requirement below.

A parameter chooses the timing. The output is either registered once, which is the default, or the block is purely combinational.

Top module: `sticky_shr128`

## Requirements
- R1: A count of 0 returns both halves unchanged, including bit 0 of the lower half.
- R2: For counts 1 to 63 the result is the 128-bit concatenation {upper, lower} shifted right logically. Result bit 0 is ORed with the OR of the discarded lower-half bits.
- R3: For a count of exactly 64 the upper result half is zero. The lower result half equals the old upper half, with its bit 0 ORed with the OR-reduction of the old lower half.
- R4: For counts 65 to 127 the upper result half is zero. The lower result half is the old upper half shifted right by (count - 64). Its bit 0 is ORed with the OR of the dropped upper-half bits and of all old lower-half bits.
- R5: For counts of 128 or more the upper result half is zero. The lower result half is 1 when any input bit is set, and 0 otherwise.
- R6: Only bit 0 carries the sticky OR. Result bits 127 down to 1 always equal the plain logical shift of the input.
- R7: An all-zero input gives an all-zero result for every count.
- R8: With output registering enabled (default), the result appears one clock after the inputs are sampled. An active-low reset clears both result halves to zero.
- R9: All counts 128 through 255 produce identical results for the same input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| src_hi | input | 64 | Upper half of the value to shift (bits 127..64) |
| src_lo | input | 64 | Lower half of the value to shift (bits 63..0) |
| shamt | input | 8 | Right shift count, 0 to 255 |
| res_hi | output | 64 | Upper half of the shifted result |
| res_lo | output | 64 | Lower half of the shifted result, bit 0 carries the sticky OR |

## Verification
The hardest case to reach from the ports is when the sticky OR is the only thing keeping result bit 0 high. This needs a count in the 65 to 127 band, a single set bit that falls exactly one position below the surviving window, and a clear bit 0 in the surviving window. Random data seldom lines up like that, so the stimulus places single-bit and dense patterns next to the window edge for each boundary count (1, 63, 64, 65, 127, 128, 200, 255). Random counts and data then fill the remaining space. The bench reference shifts a 256-bit widened copy of the input and ORs the discarded bits through an explicit mask, which is structurally unrelated to the staged shifter.

// File: rtl/sshr_pkg.sv
package sshr_pkg;

  // Count regions; the datapath uses RG_ALL to pick the collapse path.
  typedef enum logic [2:0] {
    RG_NONE = 3'd0,  // count is zero
    RG_PART = 3'd1,  // below one half width
    RG_HALF = 3'd2,  // exactly one half width
    RG_WIDE = 3'd3,  // between one and two half widths
    RG_ALL  = 3'd4   // full width or more
  } shr_region_t;

endpackage

// File: rtl/sshr_decode.sv
module sshr_decode
  import sshr_pkg::*;
#(
  parameter int HALF_W = 64,
  parameter int CNT_W  = 8
) (
  input  logic [CNT_W-1:0] shamt,
  output shr_region_t      region
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int STG    = $clog2(FULL_W);
  localparam logic [STG-1:0] HALF_CNT = HALF_W[STG-1:0];

  logic over;
  assign over = |shamt[CNT_W-1:STG];

  always_comb begin
    if (over)                            region = RG_ALL;
    else if (shamt == '0)                region = RG_NONE;
    else if (shamt[STG-1:0] == HALF_CNT) region = RG_HALF;
    else if (shamt[STG-1])               region = RG_WIDE;
    else                                 region = RG_PART;
  end
endmodule

// File: rtl/sshr_stage.sv
module sshr_stage #(
  parameter int W  = 128,
  parameter int SH = 1
) (
  input  logic [W-1:0] din,
  input  logic         sticky_in,
  input  logic         en,
  output logic [W-1:0] dout,
  output logic         sticky_out
);
  logic dropped;
  assign dropped    = |din[SH-1:0];
  assign dout       = en ? (din >> SH) : din;
  assign sticky_out = sticky_in | (en & dropped);
endmodule

// File: rtl/sticky_shr128.sv
module sticky_shr128
  import sshr_pkg::*;
#(
  parameter int HALF_W  = 64,
  parameter int CNT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HALF_W-1:0] src_hi,
  input  logic [HALF_W-1:0] src_lo,
  input  logic [CNT_W-1:0]  shamt,
  output logic [HALF_W-1:0] res_hi,
  output logic [HALF_W-1:0] res_lo
);
  localparam int FULL_W = 2 * HALF_W;
  localparam int STG    = $clog2(FULL_W);

  // Named internal events, visible to the bound checker.
  shr_region_t       region;
  logic              collapse;
  logic              any_set;
  logic              sticky_bit;
  logic [FULL_W-1:0] src_w;
  logic [FULL_W-1:0] shifted;
  logic [FULL_W-1:0] folded;

  logic [STG:0][FULL_W-1:0] chain_d;
  logic [STG:0]             chain_s;

  assign src_w = {src_hi, src_lo};

  sshr_decode #(.HALF_W(HALF_W), .CNT_W(CNT_W)) u_dec (
    .shamt  (shamt),
    .region (region)
  );

  assign chain_d[0] = src_w;
  assign chain_s[0] = 1'b0;

  for (genvar g = 0; g < STG; g++) begin : g_stage
    sshr_stage #(.W(FULL_W), .SH(1 << g)) u_stg (
      .din        (chain_d[g]),
      .sticky_in  (chain_s[g]),
      .en         (shamt[g]),
      .dout       (chain_d[g+1]),
      .sticky_out (chain_s[g+1])
    );
  end

  assign collapse   = (region == RG_ALL);
  assign any_set    = |src_w;
  assign shifted    = collapse ? '0 : chain_d[STG];
  assign sticky_bit = collapse ? any_set : chain_s[STG];
  assign folded     = {shifted[FULL_W-1:1], shifted[0] | sticky_bit};

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        res_hi <= '0;
        res_lo <= '0;
      end else begin
        res_hi <= folded[FULL_W-1:HALF_W];
        res_lo <= folded[HALF_W-1:0];
      end
    end
  end else begin : g_comb
    assign res_hi = folded[FULL_W-1:HALF_W];
    assign res_lo = folded[HALF_W-1:0];
  end
endmodule

// File: rtl/sshr_chk.sv
module sshr_chk #(
  parameter int HALF_W  = 64,
  parameter int CNT_W   = 8,
  parameter bit OUT_REG = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [HALF_W-1:0] src_hi,
  input logic [HALF_W-1:0] src_lo,
  input logic [CNT_W-1:0]  shamt,
  input logic [HALF_W-1:0] res_hi,
  input logic [HALF_W-1:0] res_lo
);
  logic [HALF_W-1:0] d_hi, d_lo;
  logic [CNT_W-1:0]  d_cnt;
  logic              d_vld;

  if (OUT_REG) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        d_hi <= '0; d_lo <= '0; d_cnt <= '0; d_vld <= 1'b0;
      end else begin
        d_hi <= src_hi; d_lo <= src_lo; d_cnt <= shamt; d_vld <= 1'b1;
      end
    end
  end else begin : g_now
    assign d_hi  = src_hi;
    assign d_lo  = src_lo;
    assign d_cnt = shamt;
    assign d_vld = 1'b1;
  end

  p_pass_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && d_cnt == '0) |-> (res_hi == d_hi && res_lo == d_lo));

  p_half_fold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && int'(d_cnt) == HALF_W) |-> (res_hi == '0 &&
      res_lo == (d_hi | HALF_W'(|d_lo))));

  p_hi_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && int'(d_cnt) >= HALF_W) |-> (res_hi == '0));

  p_collapse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && int'(d_cnt) >= 2 * HALF_W) |->
      (res_hi == '0 && res_lo == HALF_W'(|{d_hi, d_lo})));

  p_zero_in_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && d_hi == '0 && d_lo == '0) |-> (res_hi == '0 && res_lo == '0));

  p_no_growth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld && d_cnt != '0) |-> ($countones({res_hi, res_lo}) <=
      $countones({d_hi, d_lo})));
endmodule

bind sticky_shr128 sshr_chk #(.HALF_W(HALF_W), .CNT_W(CNT_W), .OUT_REG(OUT_REG)) u_chk (
  .clk(clk), .rst_n(rst_n), .src_hi(src_hi), .src_lo(src_lo),
  .shamt(shamt), .res_hi(res_hi), .res_lo(res_lo)
);

// File: tb/tb_sticky_shr128.sv
module tb_sticky_shr128;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src_hi = '0, src_lo = '0;
  logic [7:0]  shamt = '0;
  logic [63:0] res_hi, res_lo;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  sticky_shr128 dut (
    .clk(clk), .rst_n(rst_n), .src_hi(src_hi), .src_lo(src_lo),
    .shamt(shamt), .res_hi(res_hi), .res_lo(res_lo)
  );

  // Reference: widen to 256 bits, mask the discarded bits explicitly.
  function automatic logic [127:0] ref_shift(logic [127:0] v, int c);
    logic [255:0] wide, mask;
    logic [127:0] r;
    logic         lost;
    wide = {128'b0, v};
    mask = (256'b1 << c) - 256'b1;
    lost = |(wide & mask);
    r    = 128'((wide >> c));
    r[0] = r[0] | lost;
    return r;
  endfunction

  function automatic string req_of(int c);
    if (c == 0) return "R1";
    if (c < 64) return "R2";
    if (c == 64) return "R3";
    if (c < 128) return "R4";
    return "R5";
  endfunction

  task automatic compare(string tag, logic [127:0] exp);
    checks++;
    if ({res_hi, res_lo} !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h_%h expected=%h_%h", tag, res_hi, res_lo,
               exp[127:64], exp[63:0]);
    end
  endtask

  // Apply at a falling edge, result registered at the next rising edge,
  // sampled at the falling edge after that (R8 latency of one clock).
  task automatic run(logic [63:0] h, logic [63:0] l, int c, string tag);
    src_hi = h; src_lo = l; shamt = 8'(c);
    @(negedge clk);
    compare(tag, ref_shift({h, l}, c));
  endtask

  task automatic run_std(logic [63:0] h, logic [63:0] l, int c);
    run(h, l, c, req_of(c));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [127:0] keep;
    // R8 reset state with busy inputs
    src_hi = '1; src_lo = '1; shamt = 8'd3;
    repeat (3) @(negedge clk);
    compare("R8 reset", 128'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 count zero, bit 0 kept as is both ways
    run(64'h8000_0000_0000_0001, 64'h0123_4567_89AB_CDEE, 0, "R1 lsb0");
    run(64'hFFFF_0000_0000_0000, 64'h0000_0000_0000_0001, 0, "R1 lsb1");
    // R2 small counts
    run(64'h0, 64'h3, 1, "R2 c1 sticky");
    run(64'h1, 64'h0, 1, "R2 c1 carry");
    run(64'h0, 64'h8000_0000_0000_0000, 63, "R2 c63 edge");
    run(64'hAAAA_5555_0000_1111, 64'h4000_0000_0000_0000, 63, "R2 c63 lost");
    // R3 exact half
    run(64'h0000_0000_0000_0002, 64'h0000_0000_0000_0001, 64, "R3 fold");
    run(64'h0000_0000_0000_0002, 64'h0, 64, "R3 nofold");
    // R4 middle band: lone bit just below the window
    run(64'h0000_0000_0000_0001, 64'h0, 65, "R4 c65 hi bit");
    run(64'h0000_0000_0000_0004, 64'h0, 65, "R4 c65 keep");
    run(64'h8000_0000_0000_0000, 64'h0, 127, "R4 c127 top");
    run(64'h4000_0000_0000_0000, 64'h0, 127, "R4 c127 drop");
    run(64'h0, 64'h0000_0000_0001_0000, 100, "R4 lo only");
    // R5 collapse
    run(64'h0, 64'h0000_0000_0000_0001, 128, "R5 c128 lsb");
    run(64'h8000_0000_0000_0000, 64'h0, 200, "R5 c200 msb");
    run(64'h0, 64'h0, 255, "R5 c255 zero");
    // R7 zero input for many counts
    for (int c = 0; c < 256; c += 17) run(64'h0, 64'h0, c, "R7 zero");
    // R9 all saturated counts identical
    for (int c = 128; c < 256; c += 31)
      run(64'h0000_1000_0000_0000, 64'h0, c, "R9 same");
    // R6 upper bits are a plain shift: dense pattern over every boundary
    foreach (keep[i]) keep[i] = i[0];
    run(keep[127:64], keep[63:0], 1, "R6 c1");
    run(keep[127:64], keep[63:0], 63, "R6 c63");
    run(keep[127:64], keep[63:0], 66, "R6 c66");

    // R8 output holds until the clock edge
    src_hi = 64'h1; src_lo = 64'h0; shamt = 8'd0;
    @(negedge clk);
    src_hi = 64'h0; src_lo = 64'h0; shamt = 8'd0;
    #1 compare("R8 hold", {64'h1, 64'h0});
    @(negedge clk);
    compare("R8 update", 128'b0);

    // Random sweep across every region
    for (int n = 0; n < 600; n++) begin
      logic [63:0] h, l;
      int c;
      h = {$urandom, $urandom};
      l = {$urandom, $urandom};
      if (n % 3 == 1) h = 64'h1 << ($urandom % 64);
      if (n % 3 == 2) l = l & 64'h0000_0000_0000_00FF;
      c = (n % 5 == 0) ? 64 + ($urandom % 2) : int'($urandom % 256);
      run_std(h, l, c);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule